// File: doc/BRIEF.md
# Receive Frame Length and Error Checker

This block sits between the byte-wide receive stream coming from the PHY side and the receive DMA. It counts the bytes of each frame and watches the receive error input. It tells the DMA, byte by byte, whether the current byte may be written to memory. As soon as a frame runs past its size limit or an error is seen, it raises a one-cycle abort and drops all further bytes of that frame. When the frame ends, it gives one good/bad verdict so that the DMA can reclaim the buffer of a rejected frame.

A frame is the span of cycles in which `frame_act_i` is high. Bytes are qualified by `byte_vld_i`. The CRC unit supplies `fcs_ok_i` and the deserializer supplies `dribble_i`; both are valid in the first cycle after `frame_act_i` drops. Each frame is classified on a fixed priority, and the class is reported on a set of one-cycle statistic strobes. The normal limit is 1518 bytes and the minimum is 64 bytes. An optional large-frame mode raises the limit to 10240 bytes; `jumbo_en_i` is captured at the first cycle of each frame.

Top module: `rx_frame_checker`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after reset, all outputs are 0. The large-frame mode is off until a frame starts with `jumbo_en_i` high.
- R2: A frame of 64 to 1518 bytes with no receive error and `fcs_ok_i`=1 gives `eof_vld_o`=1 and `eof_good_o`=1 for one cycle, with no statistic strobe. These appear in the cycle after the first low cycle of `frame_act_i`.
- R3: `fwd_en_o` is high in the same cycle as each accepted byte (`byte_vld_i`=1 while `frame_act_i`=1) and low in every other cycle.
- R4: In normal mode, byte 1519 of a frame is not forwarded. `abort_o` pulses in the following cycle, and at the end of the frame the verdict is bad. If `fcs_ok_i`=1, `st_long_o` pulses with the verdict.
- R5: An over-limit frame whose `fcs_ok_i`=0 pulses `st_jabber_o` and neither `st_long_o` nor `st_fcs_o`.
- R6: A frame that starts with `jumbo_en_i`=1 accepts up to 10240 bytes as good; byte 10241 causes an abort as in R4. Changes of `jumbo_en_i` after the first cycle of a frame do not affect that frame.
- R7: A frame of fewer than 64 bytes is bad and pulses `st_short_o` whatever its FCS. A 64-byte frame is not short.
- R8: A frame within limits with `fcs_ok_i`=0 and `dribble_i`=0 is bad and pulses `st_fcs_o`.
- R9: A frame within limits with `fcs_ok_i`=0 and `dribble_i`=1 pulses `st_align_o` instead of `st_fcs_o`. With `fcs_ok_i`=1, `dribble_i` has no effect on the verdict.
- R10: `rx_err_i` high during a frame blocks that byte. It causes one `abort_o` pulse and one `st_symbol_o` pulse in the next cycle, and the frame ends bad. `rx_err_i` outside a frame has no effect.
- R11: After an abort, the rest of the frame gives no forwarding and no further abort until `frame_act_i` drops. The next frame is judged afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | Byte present on byte_i |
| byte_i | input | 8 | Receive byte (passes to DMA outside this block) |
| frame_act_i | input | 1 | High for the duration of a frame |
| rx_err_i | input | 1 | Receive error from the PHY |
| fcs_ok_i | input | 1 | CRC result, valid the cycle after frame_act_i falls |
| dribble_i | input | 1 | Trailing partial byte, valid with fcs_ok_i |
| jumbo_en_i | input | 1 | Large-frame limit, captured at frame start |
| fwd_en_o | output | 1 | Current byte may be written by the DMA |
| abort_o | output | 1 | One-cycle mid-frame bad-frame indication |
| eof_vld_o | output | 1 | End-of-frame verdict valid |
| eof_good_o | output | 1 | Verdict: frame good |
| st_fcs_o | output | 1 | FCS error statistic strobe |
| st_short_o | output | 1 | Short frame statistic strobe |
| st_long_o | output | 1 | Long frame statistic strobe |
| st_jabber_o | output | 1 | Jabber statistic strobe |
| st_symbol_o | output | 1 | Symbol error statistic strobe |
| st_align_o | output | 1 | Alignment error statistic strobe |

## Verification
`fwd_en_o` is combinational, so the bench samples it one time unit after driving each byte, in the same cycle. `abort_o` and `st_symbol_o` are registered at the edge that takes in the offending byte. The bench therefore expects them at the sample point of the next driven cycle, with the index of that cycle counted exactly. The verdict and the class strobes come one cycle after the first low cycle of `frame_act_i`, and they are sampled only at that one point. Any pulse of `abort_o` or `st_symbol_o` at another point counts against the expected total of one or zero.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;
  typedef enum logic [2:0] {
    CLS_GOOD,
    CLS_JABBER,
    CLS_LONG,
    CLS_SHORT,
    CLS_ALIGN,
    CLS_FCS,
    CLS_SYMBOL
  } eof_cls_e;

  typedef struct packed {
    logic fcs;
    logic short_f;
    logic long_f;
    logic jabber;
    logic align;
  } stat_t;

  // fixed priority: length faults, then short, then CRC kind, then symbol
  function automatic eof_cls_e classify(input logic too_long, input logic too_short,
                                        input logic err_seen, input logic fcs_ok,
                                        input logic dribble);
    if (too_long)           return fcs_ok ? CLS_LONG : CLS_JABBER;
    if (too_short)          return CLS_SHORT;
    if (!fcs_ok && dribble) return CLS_ALIGN;
    if (!fcs_ok)            return CLS_FCS;
    if (err_seen)           return CLS_SYMBOL;
    return CLS_GOOD;
  endfunction

  function automatic stat_t cls_to_stat(input eof_cls_e c);
    stat_t s;
    s = '0;
    unique case (c)
      CLS_FCS:    s.fcs     = 1'b1;
      CLS_SHORT:  s.short_f = 1'b1;
      CLS_LONG:   s.long_f  = 1'b1;
      CLS_JABBER: s.jabber  = 1'b1;
      CLS_ALIGN:  s.align   = 1'b1;
      default:    s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/rxfc_len_cnt.sv
module rxfc_len_cnt #(
  parameter int unsigned MIN_LEN   = 64,
  parameter int unsigned MAX_STD   = 1518,
  parameter int unsigned MAX_JUMBO = 10240,
  localparam int unsigned CNT_MAX  = (MAX_JUMBO > MAX_STD) ? MAX_JUMBO : MAX_STD,
  localparam int unsigned CNT_W    = $clog2(CNT_MAX + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic byte_vld_i,
  input  logic frame_act_i,
  input  logic jumbo_en_i,
  output logic over_now_o,
  output logic long_o,
  output logic short_o
);
  logic [CNT_W-1:0] cnt_q, cnt_base, cnt_d, limit;
  logic jumbo_q, jumbo_base, long_q, long_d, byte_in;

  assign jumbo_base = start_i ? jumbo_en_i : jumbo_q;
  assign cnt_base   = start_i ? '0 : cnt_q;
  assign byte_in    = byte_vld_i & frame_act_i;

  generate
    if (MAX_JUMBO > MAX_STD) begin : g_jumbo
      assign limit = jumbo_base ? CNT_W'(MAX_JUMBO) : CNT_W'(MAX_STD);
    end else begin : g_std
      logic unused_jumbo;
      assign unused_jumbo = jumbo_base;
      assign limit = CNT_W'(MAX_STD);
    end
  endgenerate

  assign over_now_o = byte_in & (cnt_base == limit);
  // saturate one past the limit
  assign cnt_d  = (byte_in && cnt_base <= limit) ? cnt_base + 1'b1 : cnt_base;
  assign long_d = (start_i ? 1'b0 : long_q) | over_now_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      jumbo_q <= 1'b0;
      long_q  <= 1'b0;
    end else if (frame_act_i) begin
      cnt_q   <= cnt_d;
      jumbo_q <= jumbo_base;
      long_q  <= long_d;
    end
  end

  assign long_o  = long_q;
  assign short_o = cnt_q < CNT_W'(MIN_LEN);

  a_r6_std_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_act_i && !start_i && !jumbo_q) |-> (cnt_q <= CNT_W'(MAX_STD + 1)));
endmodule

// File: rtl/rxfc_err_track.sv
module rxfc_err_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic byte_vld_i,
  input  logic frame_act_i,
  input  logic rx_err_i,
  input  logic over_now_i,
  output logic fwd_en_o,
  output logic abort_o,
  output logic symbol_o,
  output logic err_seen_o
);
  logic drop_q, drop_base, err_q, err_base, err_now, fault_now;

  assign drop_base = start_i ? 1'b0 : drop_q;
  assign err_base  = start_i ? 1'b0 : err_q;
  assign err_now   = rx_err_i & frame_act_i;
  assign fault_now = err_now | over_now_i;

  assign fwd_en_o = byte_vld_i & frame_act_i & ~drop_base & ~fault_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drop_q   <= 1'b0;
      err_q    <= 1'b0;
      abort_o  <= 1'b0;
      symbol_o <= 1'b0;
    end else begin
      abort_o  <= fault_now & ~drop_base;
      symbol_o <= err_now & ~err_base;
      if (frame_act_i) begin
        drop_q <= drop_base | fault_now;
        err_q  <= err_base | err_now;
      end
    end
  end

  assign err_seen_o = err_q;

  a_r10_symbol_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    symbol_o |=> !symbol_o);
  a_r11_abort_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);
endmodule

// File: rtl/rxfc_eof_class.sv
module rxfc_eof_class
  import rxfc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eof_i,
  input  logic long_i,
  input  logic short_i,
  input  logic err_seen_i,
  input  logic fcs_ok_i,
  input  logic dribble_i,
  output logic eof_vld_o,
  output logic eof_good_o,
  output stat_t stat_o
);
  eof_cls_e cls;
  assign cls = classify(long_i, short_i, err_seen_i, fcs_ok_i, dribble_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eof_vld_o  <= 1'b0;
      eof_good_o <= 1'b0;
      stat_o     <= '0;
    end else begin
      eof_vld_o  <= eof_i;
      eof_good_o <= eof_i && (cls == CLS_GOOD);
      stat_o     <= eof_i ? cls_to_stat(cls) : '0;
    end
  end

  a_r2_good_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_good_o |-> (eof_vld_o && stat_o == '0));
  a_r5_one_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_vld_o |-> $onehot0(stat_o));
  a_r8_strobe_at_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o != '0) |-> eof_vld_o);
endmodule

// File: rtl/rx_frame_checker.sv
module rx_frame_checker
  import rxfc_pkg::*;
#(
  parameter int unsigned MIN_LEN   = 64,
  parameter int unsigned MAX_STD   = 1518,
  parameter int unsigned MAX_JUMBO = 10240
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  input  logic       frame_act_i,
  input  logic       rx_err_i,
  input  logic       fcs_ok_i,
  input  logic       dribble_i,
  input  logic       jumbo_en_i,
  output logic       fwd_en_o,
  output logic       abort_o,
  output logic       eof_vld_o,
  output logic       eof_good_o,
  output logic       st_fcs_o,
  output logic       st_short_o,
  output logic       st_long_o,
  output logic       st_jabber_o,
  output logic       st_symbol_o,
  output logic       st_align_o
);
  logic act_q, start, eof, over_now, long_f, short_f, err_seen;
  logic [7:0] unused_byte;
  stat_t stat;

  assign unused_byte = byte_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= frame_act_i;
  end

  assign start = frame_act_i & ~act_q;
  assign eof   = act_q & ~frame_act_i;

  rxfc_len_cnt #(
    .MIN_LEN(MIN_LEN), .MAX_STD(MAX_STD), .MAX_JUMBO(MAX_JUMBO)
  ) u_len (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .byte_vld_i(byte_vld_i),
    .frame_act_i(frame_act_i), .jumbo_en_i(jumbo_en_i),
    .over_now_o(over_now), .long_o(long_f), .short_o(short_f)
  );

  rxfc_err_track u_err (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .byte_vld_i(byte_vld_i),
    .frame_act_i(frame_act_i), .rx_err_i(rx_err_i), .over_now_i(over_now),
    .fwd_en_o(fwd_en_o), .abort_o(abort_o), .symbol_o(st_symbol_o),
    .err_seen_o(err_seen)
  );

  rxfc_eof_class u_eof (
    .clk_i(clk_i), .rst_ni(rst_ni), .eof_i(eof), .long_i(long_f), .short_i(short_f),
    .err_seen_i(err_seen), .fcs_ok_i(fcs_ok_i), .dribble_i(dribble_i),
    .eof_vld_o(eof_vld_o), .eof_good_o(eof_good_o), .stat_o(stat)
  );

  assign st_fcs_o    = stat.fcs;
  assign st_short_o  = stat.short_f;
  assign st_long_o   = stat.long_f;
  assign st_jabber_o = stat.jabber;
  assign st_align_o  = stat.align;

  a_r10_abort_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(frame_act_i));
  a_r11_abort_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && frame_act_i && act_q) |-> !fwd_en_o);
  a_r4_long_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof && long_f) |=> (eof_vld_o && !eof_good_o));
  a_r10_symbol_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof && err_seen) |=> !eof_good_o);
endmodule

// File: tb/rx_frame_checker_tb_top.sv
module rx_frame_checker_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic byte_vld_i = 1'b0, frame_act_i = 1'b0, rx_err_i = 1'b0;
  logic fcs_ok_i = 1'b0, dribble_i = 1'b0, jumbo_en_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic fwd_en_o, abort_o, eof_vld_o, eof_good_o;
  logic st_fcs_o, st_short_o, st_long_o, st_jabber_o, st_symbol_o, st_align_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  rx_frame_checker dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .frame_act_i(frame_act_i), .rx_err_i(rx_err_i), .fcs_ok_i(fcs_ok_i),
    .dribble_i(dribble_i), .jumbo_en_i(jumbo_en_i), .fwd_en_o(fwd_en_o),
    .abort_o(abort_o), .eof_vld_o(eof_vld_o), .eof_good_o(eof_good_o),
    .st_fcs_o(st_fcs_o), .st_short_o(st_short_o), .st_long_o(st_long_o),
    .st_jabber_o(st_jabber_o), .st_symbol_o(st_symbol_o), .st_align_o(st_align_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int outs_vec();
    return {fwd_en_o, abort_o, eof_vld_o, eof_good_o, st_fcs_o, st_short_o,
            st_long_o, st_jabber_o, st_symbol_o, st_align_o};
  endfunction

  // strobe vector {jabber,long,short,align,fcs}
  function automatic int strobes();
    return {st_jabber_o, st_long_o, st_short_o, st_align_o, st_fcs_o};
  endfunction

  task automatic send_frame(input string req, input int len, input bit fcs,
                            input bit drib, input bit jmb_start, input bit jmb_after,
                            input int err_at);
    int limit, off, exp_fwd, fwd_n, ab_n, ab_k, sym_n, sym_k, k, exp_str;
    bit good;
    limit = jmb_start ? 10240 : 1518;
    off = -1;
    if (err_at >= 0 && err_at < len) off = err_at;
    if (len > limit && (off < 0 || limit < off)) off = limit;
    exp_fwd = (off < 0) ? len : off;
    if (len > limit)        exp_str = fcs ? 5'b01000 : 5'b10000;
    else if (len < 64)      exp_str = 5'b00100;
    else if (!fcs && drib)  exp_str = 5'b00010;
    else if (!fcs)          exp_str = 5'b00001;
    else                    exp_str = 0;
    good = (exp_str == 0) && (err_at < 0 || err_at >= len);
    fwd_n = 0; ab_n = 0; ab_k = -1; sym_n = 0; sym_k = -1; k = 0;
    @(negedge clk);
    jumbo_en_i = jmb_start; frame_act_i = 0; byte_vld_i = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      frame_act_i = 1; byte_vld_i = 1; byte_i = 8'(i);
      rx_err_i = (i == err_at);
      jumbo_en_i = (i == 0) ? jmb_start : jmb_after;
      #1;
      if (fwd_en_o) fwd_n++;
      if (abort_o) begin ab_n++; ab_k = k; end
      if (st_symbol_o) begin sym_n++; sym_k = k; end
      k++;
    end
    @(negedge clk);
    frame_act_i = 0; byte_vld_i = 0; rx_err_i = 0; fcs_ok_i = fcs; dribble_i = drib;
    #1;
    if (fwd_en_o) fwd_n++;
    if (abort_o) begin ab_n++; ab_k = k; end
    if (st_symbol_o) begin sym_n++; sym_k = k; end
    check({req, " eof not early"}, eof_vld_o, 0);
    @(negedge clk);
    fcs_ok_i = 0; dribble_i = 0;
    #1;
    check({req, " fwd count"}, fwd_n, exp_fwd);
    check({req, " abort count"}, ab_n, (off >= 0) ? 1 : 0);
    if (off >= 0) check({req, " abort cycle"}, ab_k, off + 1);
    check({req, " symbol count"}, sym_n, (err_at >= 0 && err_at < len) ? 1 : 0);
    if (err_at >= 0 && err_at < len) check({req, " symbol cycle"}, sym_k, err_at + 1);
    check({req, " eof_vld"}, eof_vld_o, 1);
    check({req, " eof_good"}, eof_good_o, good);
    check({req, " strobes"}, strobes(), exp_str);
    @(negedge clk);
    #1;
    check({req, " eof one cycle"}, eof_vld_o, 0);
  endtask

  task automatic idle_err_test();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rx_err_i = 1; frame_act_i = 0; byte_vld_i = 1;
      #1;
      check("R10 idle error no effect", outs_vec(), 0);
    end
    @(negedge clk);
    rx_err_i = 0; byte_vld_i = 0;
    #1;
    check("R10 idle error no abort", abort_o + st_symbol_o, 0);
    send_frame("R10 frame after idle error", 100, 1, 0, 0, 0, -1);
  endtask

  task automatic reset_test();
    #1;
    check("R1 outputs in reset", outs_vec(), 0);
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    #1;
    check("R1 outputs after reset", outs_vec(), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    reset_test();
    send_frame("R1 no jumbo after reset", 1600, 1, 0, 0, 0, -1);
    send_frame("R2 good min-range frame", 64, 1, 0, 0, 0, -1);
    send_frame("R2 R3 good max frame", 1518, 1, 0, 0, 0, -1);
    send_frame("R4 long frame", 1519, 1, 0, 0, 0, -1);
    send_frame("R4 R11 long frame tail ignored", 1600, 1, 0, 0, 0, -1);
    send_frame("R5 jabber", 1530, 0, 0, 0, 0, -1);
    send_frame("R6 jumbo max good", 10240, 1, 0, 1, 1, -1);
    send_frame("R6 jumbo over", 10241, 1, 0, 1, 1, -1);
    send_frame("R6 jumbo raised mid-frame", 1600, 1, 0, 0, 1, -1);
    send_frame("R7 short 63", 63, 1, 0, 0, 0, -1);
    send_frame("R7 short bad fcs", 20, 0, 1, 0, 0, -1);
    send_frame("R8 fcs error", 200, 0, 0, 0, 0, -1);
    send_frame("R9 alignment error", 200, 0, 1, 0, 0, -1);
    send_frame("R9 dribble fcs ok", 200, 1, 1, 0, 0, -1);
    send_frame("R10 rx error mid-frame", 300, 1, 0, 0, 0, 40);
    send_frame("R10 R11 rx error first byte", 80, 1, 0, 0, 0, 0);
    send_frame("R11 error then too long", 1600, 1, 0, 0, 0, 10);
    send_frame("R11 next frame clean", 100, 1, 0, 0, 0, -1);
    idle_err_test();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule